// File: doc/BRIEF.md
# Ternary Read-Port Delay Window Stage

This block is the output stage of one read port of a memory whose signals carry three-valued logic. Each bit is a pair of wires: a high rail and a low rail. A (0,1) pair means 0, a (1,0) pair means 1 and a (1,1) pair means unknown. A read starts when the port's address or its enable changes while the enable is not 0. The word fetched by the lookup logic arrives on an input in that same cycle. The stage then shapes how the data outputs move from their old contents to the new word over a window of clock steps.

At the minimum delay the outputs show the merge of the old and new words: every bit where they disagree becomes unknown. At the maximum delay the outputs settle on a value chosen by the enable. A known 1 gives the new word, and an unknown enable keeps the merge. A write can complete on the same memory while a read is live. If its address can hit the read address, the outputs immediately absorb the refreshed word as unknowns. Downstream logic therefore sees every value a real memory within these timing bounds could present.

Top module: `tern_rdwin`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output bit is unknown (q_h and q_l all ones) and no update is pending.
- R2: A read starts at a rising edge when the enable is not the 0 pair (0,1) and the enable pair or the address pairs differ from their values at the previous edge. With a 0 enable, address and fetched-data changes leave the outputs unchanged.
- R3: The enable pair decodes as 0 for (0,1), 1 for (1,0) and unknown for (1,1). The unused pair (0,0) is treated as unknown.
- R4: Let the read start at edge E. At edge E+DMAX the outputs take the fetched word if the enable was 1, or merge(fetched, current output) if it was unknown.
- R5: When DMIN < DMAX, at edge E+DMIN the outputs take merge(fetched, current output).
- R6: When DMIN equals DMAX, only the final update at E+DMAX is applied. The outputs hold until that edge.
- R7: merge(a,b) is the OR of the high rails together with the OR of the low rails, bit by bit.
- R8: A read that starts while updates are still pending cancels them. Only the new read's updates are applied, counted from its own start edge.
- R9: At an edge with write-done high, an enable that is not 0, and a write address that overlaps the read address, the outputs become merge(refresh word, output value) in that same edge. Two ternary addresses overlap when every bit position has a shared possible value.
- R10: A completed write whose address does not overlap the read address, or one that arrives while the enable is 0, leaves the outputs unchanged.
- R11: The outputs change at no edge other than those named in R4, R5 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one step of delay time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en_h | input | 1 | Read enable, high rail |
| en_l | input | 1 | Read enable, low rail |
| addr_h | input | AW | Read address, high rails |
| addr_l | input | AW | Read address, low rails |
| rd_h | input | W | Fetched word for a read starting this cycle, high rails |
| rd_l | input | W | Fetched word, low rails |
| wr_done | input | 1 | A write on the same memory completes this cycle |
| wa_h | input | AW | Completed write address, high rails |
| wa_l | input | AW | Completed write address, low rails |
| upd_h | input | W | Word re-fetched from the read address after the write, high rails |
| upd_l | input | W | Re-fetched word, low rails |
| q_h | output | W | Data outputs, high rails |
| q_l | output | W | Data outputs, low rails |

## Verification
The assertions check the following on every cycle:
- The outputs are unknown just after reset.
- A read never starts under a 0 enable.
- The delay count stays inside its window while an update is pending.
- An idle cycle leaves the outputs frozen.
- An overlapping write merges the refresh word into the previous outputs.

Only the bench's directed scenarios can show the rest:
- The exact edge at which the blended value and the final value appear.
- That the final value depends on the enable class.
- That the minimum-delay step is skipped when the two delays are equal.
- That a second read discards the first one's pending schedule.

// File: rtl/tern_rdwin.sv
module tern_rdwin #(
  parameter int W    = 8,
  parameter int AW   = 4,
  parameter int DMIN = 2,
  parameter int DMAX = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_h,
  input  logic          en_l,
  input  logic [AW-1:0] addr_h,
  input  logic [AW-1:0] addr_l,
  input  logic [W-1:0]  rd_h,
  input  logic [W-1:0]  rd_l,
  input  logic          wr_done,
  input  logic [AW-1:0] wa_h,
  input  logic [AW-1:0] wa_l,
  input  logic [W-1:0]  upd_h,
  input  logic [W-1:0]  upd_l,
  output logic [W-1:0]  q_h,
  output logic [W-1:0]  q_l
);
  localparam int CW   = $clog2(DMAX + 2);
  localparam bit EARLY = (DMIN < DMAX);

  logic          pv_eh, pv_el;
  logic [AW-1:0] pv_ah, pv_al;
  logic [W-1:0]  sv_h, sv_l;
  logic          sv_one, sv_zero;
  logic          pend;
  logic [CW-1:0] cnt;

  logic          en_zero, en_one, trig, wr_hit;
  logic [W-1:0]  src_h, src_l, mg_h, mg_l, fin_h, fin_l, bl_h, bl_l;
  logic          src_one, src_zero;
  logic [W-1:0]  nq_h, nq_l;
  logic          pend_n;
  logic [CW-1:0] cnt_n;

  assign en_zero = ~en_h & en_l;
  assign en_one  = en_h & ~en_l;
  assign trig    = !en_zero && ({en_h, en_l, addr_h, addr_l} != {pv_eh, pv_el, pv_ah, pv_al});
  assign wr_hit  = wr_done && !en_zero && (&((wa_h & addr_h) | (wa_l & addr_l)));

  assign src_h    = trig ? rd_h : sv_h;
  assign src_l    = trig ? rd_l : sv_l;
  assign src_one  = trig ? en_one : sv_one;
  assign src_zero = trig ? en_zero : sv_zero;

  assign mg_h  = src_h | q_h;
  assign mg_l  = src_l | q_l;
  assign fin_h = src_one ? src_h : (src_zero ? q_h : mg_h);
  assign fin_l = src_one ? src_l : (src_zero ? q_l : mg_l);
  assign bl_h  = src_zero ? q_h : mg_h;
  assign bl_l  = src_zero ? q_l : mg_l;

  always_comb begin
    nq_h   = q_h;
    nq_l   = q_l;
    pend_n = pend;
    cnt_n  = cnt;
    if (trig) begin
      if (DMAX == 0) begin
        nq_h   = fin_h;
        nq_l   = fin_l;
        pend_n = 1'b0;
        cnt_n  = '0;
      end else begin
        if (EARLY && DMIN == 0) begin
          nq_h = bl_h;
          nq_l = bl_l;
        end
        pend_n = 1'b1;
        cnt_n  = CW'(1);
      end
    end else if (pend) begin
      if (cnt == CW'(DMAX)) begin
        nq_h   = fin_h;
        nq_l   = fin_l;
        pend_n = 1'b0;
        cnt_n  = '0;
      end else begin
        if (EARLY && cnt == CW'(DMIN)) begin
          nq_h = bl_h;
          nq_l = bl_l;
        end
        cnt_n = cnt + CW'(1);
      end
    end
    if (wr_hit) begin
      nq_h = nq_h | upd_h;
      nq_l = nq_l | upd_l;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_h     <= '1;
      q_l     <= '1;
      pend    <= 1'b0;
      cnt     <= '0;
      pv_eh   <= 1'b0;
      pv_el   <= 1'b1;
      pv_ah   <= '0;
      pv_al   <= '0;
      sv_h    <= '1;
      sv_l    <= '1;
      sv_one  <= 1'b0;
      sv_zero <= 1'b0;
    end else begin
      q_h   <= nq_h;
      q_l   <= nq_l;
      pend  <= pend_n;
      cnt   <= cnt_n;
      pv_eh <= en_h;
      pv_el <= en_l;
      pv_ah <= addr_h;
      pv_al <= addr_l;
      if (trig) begin
        sv_h    <= rd_h;
        sv_l    <= rd_l;
        sv_one  <= en_one;
        sv_zero <= en_zero;
      end
    end
  end
endmodule

// File: rtl/tern_rdwin_chk.sv
module tern_rdwin_chk #(
  parameter int W    = 8,
  parameter int DMAX = 5,
  parameter int CW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_h,
  input logic          en_l,
  input logic [W-1:0]  upd_h,
  input logic [W-1:0]  upd_l,
  input logic [W-1:0]  q_h,
  input logic [W-1:0]  q_l,
  input logic          trig,
  input logic          wr_hit,
  input logic          pend,
  input logic [CW-1:0] cnt
);
  // R1
  reset_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_h == '1 && q_l == '1));

  // R2
  no_zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !(!en_h && en_l));

  // R8
  cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (cnt != '0 && cnt <= CW'(DMAX)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !pend && !wr_hit) |=> ($stable(q_h) && $stable(q_l)));

  // R9
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !trig && !pend) |=>
      (q_h == ($past(q_h) | $past(upd_h)) && q_l == ($past(q_l) | $past(upd_l))));
endmodule

bind tern_rdwin tern_rdwin_chk #(.W(W), .DMAX(DMAX), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_h(en_h), .en_l(en_l),
  .upd_h(upd_h), .upd_l(upd_l), .q_h(q_h), .q_l(q_l),
  .trig(trig), .wr_hit(wr_hit), .pend(pend), .cnt(cnt)
);

// File: tb/tern_rdwin_tb_top.sv
module tern_rdwin_tb_top;
  localparam int W = 8, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_h = 1'b0, en_l = 1'b1;
  logic [AW-1:0] addr_h = '0, addr_l = '0, wa_h = '0, wa_l = '0;
  logic [W-1:0] rd_h = '0, rd_l = '0, upd_h = '0, upd_l = '0;
  logic wr_done = 1'b0;
  logic [W-1:0] qa_h, qa_l, qb_h, qb_l;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  tern_rdwin #(.W(W), .AW(AW), .DMIN(2), .DMAX(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_h(en_h), .en_l(en_l), .addr_h(addr_h), .addr_l(addr_l),
    .rd_h(rd_h), .rd_l(rd_l), .wr_done(wr_done), .wa_h(wa_h), .wa_l(wa_l),
    .upd_h(upd_h), .upd_l(upd_l), .q_h(qa_h), .q_l(qa_l));

  tern_rdwin #(.W(W), .AW(AW), .DMIN(3), .DMAX(3)) dut_eq_i (
    .clk(clk), .rst_n(rst_n), .en_h(en_h), .en_l(en_l), .addr_h(addr_h), .addr_l(addr_l),
    .rd_h(rd_h), .rd_l(rd_l), .wr_done(wr_done), .wa_h(wa_h), .wa_l(wa_l),
    .upd_h(upd_h), .upd_l(upd_l), .q_h(qb_h), .q_l(qb_l));

  task automatic chk(input string tag, input logic [W-1:0] ah, al, eh, el);
    checks++;
    if (ah !== eh || al !== el) begin
      errors++;
      $display("FAIL %s: got h=%h l=%h expected h=%h l=%h", tag, ah, al, eh, el);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic start_read(input logic eh, el, input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk);
    en_h = eh; en_l = el; addr_h = a; addr_l = ~a; rd_h = v; rd_l = ~v;
    edge1();
  endtask

  task automatic settle(input logic [AW-1:0] a, input logic [7:0] v);
    start_read(1'b1, 1'b0, a, v);
    for (int k = 1; k <= 6; k++) edge1();
  endtask

  task automatic t_reset();
    chk("R1 reset A", qa_h, qa_l, 8'hFF, 8'hFF);
    chk("R1 reset B", qb_h, qb_l, 8'hFF, 8'hFF);
    start_read(1'b1, 1'b0, 4'd1, 8'h3C);
    chk("R1 hold at start", qa_h, qa_l, 8'hFF, 8'hFF);
    for (int k = 1; k <= 5; k++) edge1();
    chk("R4 first final", qa_h, qa_l, 8'h3C, 8'hC3);
    chk("R6 first final B", qb_h, qb_l, 8'h3C, 8'hC3);
  endtask

  task automatic t_window_one();
    start_read(1'b1, 1'b0, 4'd2, 8'h5A);
    edge1();
    chk("R11 before min", qa_h, qa_l, 8'h3C, 8'hC3);
    edge1();
    chk("R5 R7 blend at min", qa_h, qa_l, 8'h7E, 8'hE7);
    chk("R6 no blend B", qb_h, qb_l, 8'h3C, 8'hC3);
    edge1();
    chk("R6 final B", qb_h, qb_l, 8'h5A, 8'hA5);
    edge1();
    chk("R11 inside window", qa_h, qa_l, 8'h7E, 8'hE7);
    edge1();
    chk("R4 final one", qa_h, qa_l, 8'h5A, 8'hA5);
  endtask

  task automatic t_window_x();
    start_read(1'b1, 1'b1, 4'd3, 8'h0F);
    edge1(); edge1();
    chk("R5 blend unknown", qa_h, qa_l, 8'h5F, 8'hF5);
    for (int k = 3; k <= 5; k++) edge1();
    chk("R4 final unknown", qa_h, qa_l, 8'h5F, 8'hF5);
    settle(4'd4, 8'h00);
    chk("R4 restore", qa_h, qa_l, 8'h00, 8'hFF);
  endtask

  task automatic t_zero_enable();
    @(negedge clk);
    en_h = 1'b0; en_l = 1'b1; addr_h = 4'd5; addr_l = ~4'd5; rd_h = 8'hAA; rd_l = 8'h55;
    for (int k = 0; k <= 6; k++) edge1();
    chk("R2 zero enable no read", qa_h, qa_l, 8'h00, 8'hFF);
  endtask

  task automatic t_illegal_enable();
    start_read(1'b0, 1'b0, 4'd6, 8'hF0);
    for (int k = 1; k <= 5; k++) edge1();
    chk("R3 pair 00 as unknown", qa_h, qa_l, 8'hF0, 8'hFF);
    settle(4'd7, 8'h00);
  endtask

  task automatic t_replace();
    start_read(1'b1, 1'b0, 4'd8, 8'h11);
    start_read(1'b1, 1'b0, 4'd9, 8'h22);
    edge1();
    chk("R8 old blend dropped", qa_h, qa_l, 8'h00, 8'hFF);
    edge1();
    chk("R8 new blend", qa_h, qa_l, 8'h22, 8'hFF);
    edge1(); edge1();
    chk("R8 old final dropped", qa_h, qa_l, 8'h22, 8'hFF);
    edge1();
    chk("R8 new final", qa_h, qa_l, 8'h22, 8'hDD);
    edge1();
  endtask

  task automatic t_write_hit();
    @(negedge clk);
    wr_done = 1'b1; wa_h = 4'b1001; wa_l = 4'b0111; upd_h = 8'h44; upd_l = 8'hBB;
    edge1();
    chk("R9 overlap merge", qa_h, qa_l, 8'h66, 8'hFF);
    @(negedge clk);
    wr_done = 1'b0;
    edge1();
    chk("R11 after merge", qa_h, qa_l, 8'h66, 8'hFF);
  endtask

  task automatic t_write_miss();
    settle(4'd10, 8'h22);
    @(negedge clk);
    wr_done = 1'b1; wa_h = 4'd11; wa_l = ~4'd11; upd_h = 8'hFF; upd_l = 8'hFF;
    edge1();
    chk("R10 no overlap", qa_h, qa_l, 8'h22, 8'hDD);
    @(negedge clk);
    en_h = 1'b0; en_l = 1'b1; wa_h = 4'd10; wa_l = ~4'd10;
    edge1();
    chk("R10 zero enable write", qa_h, qa_l, 8'h22, 8'hDD);
    @(negedge clk);
    wr_done = 1'b0;
    edge1();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_window_one();
    t_window_x();
    t_zero_enable();
    t_illegal_enable();
    t_replace();
    t_write_hit();
    t_write_miss();
    finish_run();
  end
endmodule